// File: doc/BRIEF.md
# Banked Interrupt Controller with Programmable Priority Slots

This block collects level-sensitive interrupt requests from up to 96 peripheral sources and presents them to a processor core as two request lines, a normal one and a fast one, plus an idle-wake line. Sources are grouped in banks of 32. Each bank has its own enable (mask) word and its own routing (level) word, and exposes three read-only views: the raw inputs, the enabled requests routed to the normal line, and the enabled requests routed to the fast line. A source stays pending for as long as its input is high. Software acknowledges a request by clearing the source's enable bit.

Arbitration among normal-line requests runs through a table of priority slots, one slot per source. Each slot names a source and carries a valid flag. The lowest-numbered valid slot whose named source has an enabled, normal-routed request wins. The winner is reported in a single packed word that holds a valid flag and the source number. A control bit chooses whether only enabled requests, or any raw request, may wake the core from idle. Software reaches every register through a simple word-wide read/write port. Read data is registered.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every enable bit, routing bit and control bit is 0, every priority slot reads 0 (invalid), and `irq_o`, `fiq_o`, `wake_o` and `rdata` are 0.
- R2: Bank b (base 0x000, 0x09C, 0x130 for b = 0, 1, 2) holds a read/write enable word at base+0x04 and a read/write routing word at base+0x08. Bit n of bank b belongs to source 32·b+n.
- R3: base+0x10 of each bank reads the raw source inputs of that bank, whatever the enable and routing bits are.
- R4: base+0x00 reads raw AND enable AND NOT routing (the normal-line view). base+0x0C reads raw AND enable AND routing (the fast-line view).
- R5: `irq_o` is the OR of all normal-line view bits and `fiq_o` is the OR of all fast-line view bits. Each is registered, so it follows the inputs one clock later.
- R6: The priority slot of source i sits at 0x1C+4·i for i<32, at 0xB0+4·(i−32) for 32≤i<64, and at 0x144+4·(i−64) for i≥64. A slot word keeps a source index in bits 6:0 and a valid flag in bit 31. All other bits read 0.
- R7: The word at 0x018 reads {1, source[14:0], 16'h0} for the source named by the lowest-numbered valid slot whose source has a set bit in the normal-line view. It reads 0 when no slot qualifies. Invalid slots, and slots that name a source ≥ 96, never qualify.
- R8: A source whose routing bit is 1 never wins the arbitration at 0x018, even when it is enabled and pending.
- R9: Control bit 0 sits at 0x014. When it is 1, `wake_o` is the registered OR of the enabled raw requests. When it is 0, `wake_o` is the registered OR of all raw requests.
- R10: Writes to the three view registers and to 0x018 change nothing. Reads of any address that holds no register return 0.
- R11: `rdata` carries the addressed word in the cycle after a cycle with `rd_en` high, and is 0 after a cycle with `rd_en` low.
- R12: Requests are not latched. When a source input falls, its bits in every view clear, with no software action needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_i | input | 96 | Level-sensitive source requests |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle wake request |

## Verification
The hardest cases are in the slot table. The bench places an invalid slot and a slot that names a source beyond the last one so that each would win if it were not skipped. A design that ignored the valid flag or the range check would then report source 7 or a bogus index instead of 0. The bench also routes the top-slot source to the fast line while it stays pending: a design that arbitrated on enabled requests alone would report 40 instead of 5. Writes to the read-only views, followed by read-backs, catch a decoder that lets those writes alias onto the enable word. Toggling the wake-control bit with an unenabled source pending catches a wake line that ignores the control bit or uses the wrong gating.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  localparam int BANK_W    = 32;
  localparam int MAX_BANKS = 3;
  localparam int IDX_W     = 7;

  // register offsets inside one bank
  localparam int OFF_NRM  = 'h00;
  localparam int OFF_ENA  = 'h04;
  localparam int OFF_RTE  = 'h08;
  localparam int OFF_FST  = 'h0C;
  localparam int OFF_RAW  = 'h10;
  localparam int OFF_CTL  = 'h14;
  localparam int OFF_WIN  = 'h18;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } slot_sel_t;

  function automatic int bank_base(input int b);
    case (b)
      0:       return 'h000;
      1:       return 'h09C;
      default: return 'h130;
    endcase
  endfunction

  function automatic int slot_group_base(input int g);
    case (g)
      0:       return 'h01C;
      1:       return 'h0B0;
      default: return 'h144;
    endcase
  endfunction

  // map a byte address onto a priority slot, if it names one
  function automatic slot_sel_t slot_decode(input logic [15:0] a, input int nsrc);
    slot_sel_t r;
    int        ai;
    int        k;
    r  = '0;
    ai = int'(a);
    for (int g = 0; g < MAX_BANKS; g++) begin
      if (ai >= slot_group_base(g) && ai < slot_group_base(g) + 4 * BANK_W
          && a[1:0] == 2'b00) begin
        k = g * BANK_W + (ai - slot_group_base(g)) / 4;
        if (k < nsrc) begin
          r.hit = 1'b1;
          r.idx = IDX_W'(k);
        end
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] pack_winner(input logic v, input logic [14:0] src);
    return {v, src, 16'h0000};
  endfunction

  function automatic logic [31:0] pack_slot(input logic v, input logic [IDX_W-1:0] idx);
    return {v, {(31 - IDX_W){1'b0}}, idx};
  endfunction

endpackage

// File: rtl/ipc_bank.sv
module ipc_bank #(
  parameter int LIVE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ena,
  input  logic        wr_rte,
  input  logic [31:0] wdata,
  input  logic [31:0] src_i,
  output logic [31:0] ena_q,
  output logic [31:0] rte_q,
  output logic [31:0] raw_o,
  output logic [31:0] nrm_o,
  output logic [31:0] fst_o
);
  localparam logic [31:0] LIVE_MASK = (LIVE >= 32) ? 32'hFFFF_FFFF : ((32'd1 << LIVE) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q <= '0;
      rte_q <= '0;
    end else begin
      if (wr_ena) ena_q <= wdata & LIVE_MASK;
      if (wr_rte) rte_q <= wdata & LIVE_MASK;
    end
  end

  assign raw_o = src_i & LIVE_MASK;
  assign nrm_o = raw_o & ena_q & ~rte_q;
  assign fst_o = raw_o & ena_q & rte_q;
endmodule

// File: rtl/ipc_prio_table.sv
module ipc_prio_table
  import ipc_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int SRC_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SRC_W-1:0]   wr_slot,
  input  logic [31:0]        wdata,
  input  logic [NUM_SRC-1:0] eligible,
  input  logic [SRC_W-1:0]   rd_slot,
  output logic [31:0]        rd_word,
  output logic               win_valid,
  output logic [SRC_W-1:0]   win_src
);
  logic             slot_v   [NUM_SRC];
  logic [SRC_W-1:0] slot_idx [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_v[s]   <= 1'b0;
        slot_idx[s] <= '0;
      end else if (wr_en && wr_slot == SRC_W'(s)) begin
        slot_v[s]   <= wdata[31];
        slot_idx[s] <= wdata[SRC_W-1:0];
      end
    end
  end

  function automatic logic slot_qualifies(input logic v, input logic [SRC_W-1:0] idx,
                                          input logic [NUM_SRC-1:0] elig);
    if (!v) return 1'b0;
    if (int'(idx) >= NUM_SRC) return 1'b0;
    return elig[idx];
  endfunction

  // scan from the top so the lowest-numbered qualifying slot is left standing
  always_comb begin
    win_valid = 1'b0;
    win_src   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (slot_qualifies(slot_v[i], slot_idx[i], eligible)) begin
        win_valid = 1'b1;
        win_src   = slot_idx[i];
      end
    end
  end

  assign rd_word = pack_slot(slot_v[rd_slot], IDX_W'(slot_idx[rd_slot]));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import ipc_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int PAD       = NUM_BANKS * BANK_W;
  localparam int SRC_W     = $clog2(NUM_SRC);

  logic [15:0]    addr16;
  logic [PAD-1:0] src_pad;
  logic [PAD-1:0] mask_all, level_all, raw_all, irq_pend_all, fiq_pend_all;
  logic [31:0]    b_ena [NUM_BANKS];
  logic [31:0]    b_rte [NUM_BANKS];
  logic [31:0]    b_raw [NUM_BANKS];
  logic [31:0]    b_nrm [NUM_BANKS];
  logic [31:0]    b_fst [NUM_BANKS];
  logic           ctl_q;
  slot_sel_t      sdec;
  logic           slot_wr;
  logic [31:0]    slot_word;
  logic           hp_valid;
  logic [SRC_W-1:0] hp_src;
  logic [31:0]    rd_val;

  assign addr16  = 16'(addr);
  assign src_pad = PAD'(src_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LIVE = (NUM_SRC - b * BANK_W >= BANK_W) ? BANK_W : (NUM_SRC - b * BANK_W);
    logic hit_ena, hit_rte;
    assign hit_ena = wr_en && addr16 == 16'(bank_base(b) + OFF_ENA);
    assign hit_rte = wr_en && addr16 == 16'(bank_base(b) + OFF_RTE);

    ipc_bank #(.LIVE(LIVE)) i_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ena (hit_ena),
      .wr_rte (hit_rte),
      .wdata  (wdata),
      .src_i  (src_pad[b*BANK_W +: BANK_W]),
      .ena_q  (b_ena[b]),
      .rte_q  (b_rte[b]),
      .raw_o  (b_raw[b]),
      .nrm_o  (b_nrm[b]),
      .fst_o  (b_fst[b])
    );

    assign mask_all[b*BANK_W +: BANK_W]     = b_ena[b];
    assign level_all[b*BANK_W +: BANK_W]    = b_rte[b];
    assign raw_all[b*BANK_W +: BANK_W]      = b_raw[b];
    assign irq_pend_all[b*BANK_W +: BANK_W] = b_nrm[b];
    assign fiq_pend_all[b*BANK_W +: BANK_W] = b_fst[b];
  end

  // control word lives in bank 0 only
  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= 1'b0;
    else if (wr_en && addr16 == 16'(bank_base(0) + OFF_CTL)) ctl_q <= wdata[0];
  end

  assign sdec    = slot_decode(addr16, NUM_SRC);
  assign slot_wr = wr_en && sdec.hit;

  ipc_prio_table #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (slot_wr),
    .wr_slot   (sdec.idx[SRC_W-1:0]),
    .wdata     (wdata),
    .eligible  (irq_pend_all[NUM_SRC-1:0]),
    .rd_slot   (sdec.idx[SRC_W-1:0]),
    .rd_word   (slot_word),
    .win_valid (hp_valid),
    .win_src   (hp_src)
  );

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr16 == 16'(bank_base(b) + OFF_NRM)) rd_val = b_nrm[b];
      if (addr16 == 16'(bank_base(b) + OFF_ENA)) rd_val = b_ena[b];
      if (addr16 == 16'(bank_base(b) + OFF_RTE)) rd_val = b_rte[b];
      if (addr16 == 16'(bank_base(b) + OFF_FST)) rd_val = b_fst[b];
      if (addr16 == 16'(bank_base(b) + OFF_RAW)) rd_val = b_raw[b];
    end
    if (addr16 == 16'(bank_base(0) + OFF_CTL)) rd_val = {31'h0, ctl_q};
    if (addr16 == 16'(bank_base(0) + OFF_WIN)) rd_val = pack_winner(hp_valid, 15'(hp_src));
    if (sdec.hit) rd_val = slot_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      rdata  <= rd_en ? rd_val : 32'h0;
      irq_o  <= |irq_pend_all;
      fiq_o  <= |fiq_pend_all;
      wake_o <= ctl_q ? |(raw_all & mask_all) : |raw_all;
    end
  end
endmodule

// File: rtl/ipc_chk.sv
module ipc_chk #(
  parameter int PAD   = 96,
  parameter int SRC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [31:0]      rdata,
  input logic [PAD-1:0]   src_pad,
  input logic [PAD-1:0]   mask_all,
  input logic [PAD-1:0]   level_all,
  input logic [PAD-1:0]   irq_pend_all,
  input logic             ctl_q,
  input logic             hp_valid,
  input logic [SRC_W-1:0] hp_src,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             wake_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    irq_o == $past(|(src_pad & mask_all & ~level_all))); // R5
  AST_FIQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    fiq_o == $past(|(src_pad & mask_all & level_all))); // R5
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid |-> irq_pend_all[hp_src]); // R7
  AST_NO_WINNER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_all == '0) |-> !hp_valid); // R7
  AST_WINNER_NOT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid |-> !level_all[hp_src]); // R8
  AST_WAKE_GATING: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    wake_o == $past(ctl_q ? |(src_pad & mask_all) : |src_pad)); // R9
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(rd_en) |-> rdata == 32'h0); // R11
endmodule

bind irq_prio_ctrl ipc_chk #(.PAD(PAD), .SRC_W(SRC_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .rdata        (rdata),
  .src_pad      (src_pad),
  .mask_all     (mask_all),
  .level_all    (level_all),
  .irq_pend_all (irq_pend_all),
  .ctl_q        (ctl_q),
  .hp_valid     (hp_valid),
  .hp_src       (hp_src),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .wake_o       (wake_o)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int N = 96;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [9:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] src = '0;
  logic         irq_o, fiq_o, wake_o;

  int n_run  = 0;
  int n_fail = 0;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_i(src), .irq_o(irq_o), .fiq_o(fiq_o),
    .wake_o(wake_o)
  );

  always #10 clk = ~clk;

  // vector: {src, enable, routing, expected irq_o, expected fiq_o}
  localparam int NV = 6;
  localparam logic [3*N+1:0] VEC [NV] = '{
    {{N{1'b0}},                       {N{1'b1}},                       {N{1'b0}},        2'b00},
    {N'(1),                           {N{1'b0}},                       {N{1'b0}},        2'b00},
    {N'(1) | (N'(1) << 50),           N'(1) << 50,                     {N{1'b0}},        2'b10},
    {N'(1) << 95,                     N'(1) << 95,                     N'(1) << 95,      2'b01},
    {(N'(1) << 33) | (N'(1) << 70),   (N'(1) << 33) | (N'(1) << 70),   N'(1) << 70,      2'b11},
    {{N{1'b1}},                       {N{1'b1}},                       {N{1'b1}},        2'b01}
  };

  function automatic logic [9:0] bank_addr(input int b, input int off);
    int base;
    base = (b == 0) ? 'h000 : (b == 1) ? 'h09C : 'h130;
    return 10'(base + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] vs, vm, vl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 fiq_o", 32'(fiq_o), 0);
    check("R1 wake_o", 32'(wake_o), 0);
    check("R1 rdata", rdata, 0);
    rd('h004, d); check("R1 enable", d, 0);
    rd('h014, d); check("R1 control", d, 0);
    rd('h0B0, d); check("R1 slot32 invalid", d, 0);
    rd('h018, d); check("R1 winner", d, 0);

    // R4 R5 vector table
    for (int v = 0; v < NV; v++) begin
      vs = VEC[v][3*N+1 -: N];
      vm = VEC[v][2*N+1 -: N];
      vl = VEC[v][N+1 -: N];
      for (int b = 0; b < 3; b++) begin
        wr(bank_addr(b, 'h04), vm[b*32 +: 32]);
        wr(bank_addr(b, 'h08), vl[b*32 +: 32]);
      end
      src = vs;
      @(negedge clk); @(negedge clk);
      check($sformatf("R5 irq_o vec%0d", v), 32'(irq_o), 32'(VEC[v][1]));
      check($sformatf("R5 fiq_o vec%0d", v), 32'(fiq_o), 32'(VEC[v][0]));
      for (int b = 0; b < 3; b++) begin
        rd(bank_addr(b, 'h00), d);
        check($sformatf("R4 normal view vec%0d bank%0d", v, b), d, vs[b*32 +: 32] & vm[b*32 +: 32] & ~vl[b*32 +: 32]);
        rd(bank_addr(b, 'h0C), d);
        check($sformatf("R4 fast view vec%0d bank%0d", v, b), d, vs[b*32 +: 32] & vm[b*32 +: 32] & vl[b*32 +: 32]);
      end
    end

    // R2 enable / routing read-back
    wr('h134, 32'hFFFF_FFFF);
    rd('h134, d); check("R2 bank2 enable", d, 32'hFFFF_FFFF);
    wr('h0A4, 32'hA5A5_0000);
    rd('h0A4, d); check("R2 bank1 routing", d, 32'hA5A5_0000);

    // clear everything
    src = '0;
    for (int b = 0; b < 3; b++) begin
      wr(bank_addr(b, 'h04), 0);
      wr(bank_addr(b, 'h08), 0);
    end

    // R6 slot table
    wr('h01C, 32'h8000_0028);  // slot0 -> source 40
    wr('h020, 32'h8000_0005);  // slot1 -> source 5
    wr('h024, 32'h0000_0007);  // slot2 invalid -> source 7
    wr('h028, 32'h8000_0060);  // slot3 -> source 96 (out of range)
    wr('h02C, 32'hFFFF_FFFF);
    rd('h02C, d); check("R6 slot4 field bits", d, 32'h8000_007F);
    wr('h144, 32'h8000_0041);
    rd('h144, d); check("R6 slot64 address", d, 32'h8000_0041);
    rd('h020, d); check("R6 slot1 read", d, 32'h8000_0005);

    // R7 winner
    wr('h004, (32'd1 << 5) | (32'd1 << 7));
    wr('h0A0, 32'd1 << 8);
    src = (N'(1) << 5) | (N'(1) << 7) | (N'(1) << 40);
    rd('h018, d); check("R7 slot0 wins", d, 32'h8028_0000);
    src = (N'(1) << 5) | (N'(1) << 7);
    rd('h018, d); check("R7 slot1 wins", d, 32'h8005_0000);
    src = N'(1) << 7;
    rd('h018, d); check("R7 invalid and out-of-range slots skipped", d, 32'h0);

    // R8 fast-routed source cannot win
    wr('h0A4, 32'd1 << 8);
    src = (N'(1) << 5) | (N'(1) << 40);
    rd('h018, d); check("R8 fast source skipped", d, 32'h8005_0000);
    check("R8 fiq_o raised", 32'(fiq_o), 1);
    wr('h0A4, 0);

    // R9 wake gating
    wr('h004, 0);
    wr('h0A0, 0);
    src = N'(1) << 7;
    @(negedge clk);
    check("R9 wake any pending", 32'(wake_o), 1);
    wr('h014, 1);
    @(negedge clk);
    check("R9 wake gated by enable", 32'(wake_o), 0);
    wr('h004, 32'd1 << 7);
    @(negedge clk);
    check("R9 wake enabled pending", 32'(wake_o), 1);

    // R10 writes to views ignored, unmapped reads zero
    wr('h010, 32'hFFFF_FFFF);
    wr('h000, 32'hFFFF_FFFF);
    wr('h00C, 32'hFFFF_FFFF);
    wr('h018, 32'hFFFF_FFFF);
    rd('h004, d); check("R10 enable untouched", d, 32'h80);
    rd('h008, d); check("R10 routing untouched", d, 32'h0);
    rd('h010, d); check("R10 raw view", d, 32'h80);
    rd('h000, d); check("R10 normal view", d, 32'h80);
    rd('h018, d); check("R10 winner", d, 32'h0);
    rd('h1C4, d); check("R10 unmapped 0x1C4", d, 32'h0);
    rd('h3FC, d); check("R10 unmapped 0x3FC", d, 32'h0);

    // R3 raw view ignores enable
    src = N'(1) << 40;
    rd('h0AC, d); check("R3 raw bank1", d, 32'h100);

    // R12 no latching
    src = N'(1) << 7;
    rd('h010, d); check("R12 raw follows", d, 32'h80);
    src = '0;
    rd('h000, d); check("R12 pending drops", d, 32'h0);
    @(negedge clk);
    check("R12 irq_o drops", 32'(irq_o), 0);

    // R11 read data quiet when idle
    rd('h004, d); check("R11 read data", d, 32'h80);
    @(negedge clk);
    check("R11 rdata idle", rdata, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule